// File: doc/BRIEF.md
# Configurable Serial Pointer Receiver

This block is a receive-only asynchronous serial port meant for a serial pointing device, and it serves equally well as a plain receive channel. It watches one serial line. It finds the start of each character with 16x oversampling, and it takes every bit at its middle. Software sets the bit rate, the character length, the parity mode and the stop bit count at run time through static configuration inputs.

Received characters go into a small set of holding registers, which a read port exposes. In byte mode every character raises the interrupt. A pointing device sends its movement as groups of three characters, so packet mode collects three characters in arrival order and raises the interrupt only when the third one lands. Reading the status register acknowledges the interrupt. Parity errors, framing errors and unread data lost to new arrivals are each reported in their own status bit.

Top module: `mouse_rx`

## Requirements
- R1: One bit time is 16*(cfg_div+1) clock cycles. Characters sent at that rate are received correctly for any cfg_div value.
- R2: cfg_len8=1 selects 8 data bits and cfg_len8=0 selects 7. Bits arrive least significant first. A 7-bit character is stored with bit 7 cleared.
- R3: cfg_par selects the parity mode: 2'b00 none, 2'b01 even, 2'b10 odd, 2'b11 treated as none. A received parity bit that does not match sets status bit 1.
- R4: cfg_stop2=1 expects two stop bits and cfg_stop2=0 expects one. A low level at any stop bit sample sets status bit 2.
- R5: A low pulse shorter than half a bit time is rejected as a false start and stores nothing.
- R6: In byte mode (cfg_pkt3=0), each accepted character is written to address 1. The same character sets status bit 0 and irq, and makes the count field (status bits 5:4) equal to 1.
- R7: In packet mode (cfg_pkt3=1), characters are written to addresses 1, 2 and 3 in arrival order, and the count field advances with each one. Status bit 0 and irq are set only when the third character is written.
- R8: A read with rd_en=1 and rd_addr=0 returns the status and, at that clock edge, clears the ready flag, irq, the error flags, the overrun flag and the count.
- R9: A character that completes while the ready flag is set is discarded, the stored data is unchanged, and status bit 3 (overrun) is set.
- R10: After reset the status reads 0, irq is low and every data entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial receive line, idles high |
| cfg_div | input | 16 | Oversample tick divisor, tick every cfg_div+1 clocks |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 none |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_pkt3 | input | 1 | 1: interrupt per three characters, 0: per character |
| rd_en | input | 1 | Read strobe, clears status when rd_addr is 0 |
| rd_addr | input | 2 | 0: status, 1..3: data entries |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| irq | output | 1 | Interrupt, high while data is ready |

## Verification
A wrong bit counter or sample point shows at the ports as a shifted or corrupted character at address 1, or as a false framing or parity flag, as soon as the first character has finished. A wrong packet count shows as irq rising after the first or second character of a group, or as data landing in the wrong entry, before the third character completes. If the ready flag is stuck or left uncleared, the status read after the acknowledge is non-zero, or the next character raises an overrun instead of being stored. Both show within one character time.

// File: rtl/mrx_pkg.sv
// Package: shared encodings for the serial pointer receiver.
// Assumes: included first in compile order.
package mrx_pkg;

    // Receive framing state machine states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    // Parity mode codes on cfg_par (2'b11 behaves as none).
    localparam logic [1:0] PAR_NONE = 2'b00;
    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

    // Status register bit positions.
    localparam int STAT_RDY  = 0;
    localparam int STAT_PERR = 1;
    localparam int STAT_FERR = 2;
    localparam int STAT_OVR  = 3;
    localparam int STAT_CNT  = 4;

endpackage

// File: rtl/mrx_tick.sv
// Module: mrx_tick
// Produces a one-cycle oversample tick every cfg_div+1 clock cycles.
// Assumes: cfg_div is static while a character is being received.
module mrx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Count clock cycles and emit a tick when the divisor is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= cfg_div) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg_div != '0) |=> !tick); // R1

endmodule

// File: rtl/mrx_frame.sv
// Module: mrx_frame
// Synchronises the serial line, validates the start bit at mid-bit,
// shifts data bits least significant first, checks parity and stop bits,
// and emits a one-cycle done pulse with the character and error flags.
// Assumes: configuration is static during a character; OVS is a power of 2.
module mrx_frame
    import mrx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int DATA_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rxd,
    input  logic                tick,
    input  logic                cfg_len8,
    input  logic [1:0]          cfg_par,
    input  logic                cfg_stop2,
    output logic                done,
    output logic [DATA_MAX-1:0] data,
    output logic                perr,
    output logic                ferr
);

    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_MAX);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    logic [1:0]          sync_q;
    logic                rx_s;
    rx_state_e           st;
    logic [CNT_W-1:0]    cnt_q;
    logic [BIT_W-1:0]    bit_q;
    logic [DATA_MAX-1:0] sh_q;
    logic                par_acc_q;
    logic                perr_q;
    logic                ferr_q;
    logic                stop_q;

    logic [BIT_W-1:0]    last_bit;
    logic                par_on;
    logic                par_exp;
    logic                ferr_now;

    assign rx_s = sync_q[1];

    // Bring the asynchronous line into the clock domain, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Derive per-character constants from the configuration.
    always_comb begin
        last_bit = cfg_len8 ? BIT_W'(DATA_MAX - 1) : BIT_W'(DATA_MAX - 2);
        par_on   = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
        par_exp  = (cfg_par == PAR_ODD) ? ~par_acc_q : par_acc_q;
        ferr_now = ferr_q | ~rx_s;
    end

    // Framing state machine: start check, data shift, parity, stop bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt_q     <= '0;
            bit_q     <= '0;
            sh_q      <= '0;
            par_acc_q <= 1'b0;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
            stop_q    <= 1'b0;
            done      <= 1'b0;
            data      <= '0;
            perr      <= 1'b0;
            ferr      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (st)
                    ST_IDLE: begin
                        if (!rx_s) begin
                            st    <= ST_START;
                            cnt_q <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt_q == HALF) begin
                            cnt_q <= '0;
                            if (!rx_s) begin
                                st        <= ST_DATA;
                                bit_q     <= '0;
                                par_acc_q <= 1'b0;
                                perr_q    <= 1'b0;
                                ferr_q    <= 1'b0;
                                stop_q    <= 1'b0;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q == LAST) begin
                            cnt_q     <= '0;
                            sh_q      <= {rx_s, sh_q[DATA_MAX-1:1]};
                            par_acc_q <= par_acc_q ^ rx_s;
                            if (bit_q == last_bit) st <= par_on ? ST_PAR : ST_STOP;
                            else                   bit_q <= bit_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt_q == LAST) begin
                            cnt_q  <= '0;
                            perr_q <= (rx_s != par_exp);
                            st     <= ST_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            if (cfg_stop2 && !stop_q) begin
                                stop_q <= 1'b1;
                                ferr_q <= ferr_now;
                            end else begin
                                done <= 1'b1;
                                data <= cfg_len8 ? sh_q : {1'b0, sh_q[DATA_MAX-1:1]};
                                perr <= perr_q;
                                ferr <= ferr_now;
                                st   <= ST_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    AST_SHORT_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_len8) |-> !data[DATA_MAX-1]); // R2

    AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START && tick && cnt_q == HALF && rx_s) |=> (st == ST_IDLE)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

endmodule

// File: rtl/mrx_buf.sv
// Module: mrx_buf
// Holds received characters, keeps the status flags and the interrupt,
// and returns status or a data entry on the read port.
// Assumes: done is a single-cycle pulse; status read clears at the edge.
module mrx_buf
    import mrx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PKT_LEN = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             done,
    input  logic [DATA_W-1:0]                din,
    input  logic                             din_perr,
    input  logic                             din_ferr,
    input  logic                             cfg_pkt3,
    input  logic                             rd_en,
    input  logic [$clog2(PKT_LEN+1)-1:0]     rd_addr,
    output logic [DATA_W-1:0]                rd_data,
    output logic                             irq
);

    localparam int ADDR_W = $clog2(PKT_LEN + 1);
    localparam int CNT_W  = $clog2(PKT_LEN + 1);
    localparam int SLOT_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

    logic [DATA_W-1:0] ent [PKT_LEN];
    logic              rdy_q, perr_q, ferr_q, ovr_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              rd_stat;
    logic [CNT_W-1:0]  base_cnt;
    logic              n_rdy, n_perr, n_ferr, n_ovr;
    logic [CNT_W-1:0]  n_cnt;
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    logic [DATA_W-1:0] stat;

    // Next-state for flags, count and the write slot.
    always_comb begin
        rd_stat  = rd_en && (rd_addr == '0);
        base_cnt = rd_stat ? '0 : cnt_q;
        n_rdy    = rdy_q  && !rd_stat;
        n_perr   = perr_q && !rd_stat;
        n_ferr   = ferr_q && !rd_stat;
        n_ovr    = ovr_q  && !rd_stat;
        n_cnt    = base_cnt;
        wr_en    = 1'b0;
        wr_slot  = '0;
        if (done) begin
            if (n_rdy) begin
                n_ovr = 1'b1;
            end else begin
                wr_en   = 1'b1;
                wr_slot = cfg_pkt3 ? SLOT_W'(base_cnt) : '0;
                n_perr  = n_perr | din_perr;
                n_ferr  = n_ferr | din_ferr;
                n_cnt   = cfg_pkt3 ? base_cnt + 1'b1 : CNT_W'(1);
                n_rdy   = !cfg_pkt3 || (base_cnt == CNT_W'(PKT_LEN - 1));
            end
        end
    end

    // Register the flags and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q  <= 1'b0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            rdy_q  <= n_rdy;
            perr_q <= n_perr;
            ferr_q <= n_ferr;
            ovr_q  <= n_ovr;
            cnt_q  <= n_cnt;
        end
    end

    // One holding register per packet position.
    for (genvar g = 0; g < PKT_LEN; g++) begin : g_ent
        // Capture the character when this slot is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   ent[g] <= '0;
            else if (wr_en && wr_slot == SLOT_W'(g))      ent[g] <= din;
        end
    end

    // Assemble status and select the read data.
    always_comb begin
        stat                     = '0;
        stat[STAT_RDY]           = rdy_q;
        stat[STAT_PERR]          = perr_q;
        stat[STAT_FERR]          = ferr_q;
        stat[STAT_OVR]           = ovr_q;
        stat[STAT_CNT +: CNT_W]  = cnt_q;
        rd_data = '0;
        if (rd_addr == '0) rd_data = stat;
        for (int i = 0; i < PKT_LEN; i++) begin
            if (rd_addr == ADDR_W'(i + 1)) rd_data = ent[i];
        end
    end

    assign irq = rdy_q;

    AST_PKT_IRQ_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdy_q) && cfg_pkt3) |-> (cnt_q == CNT_W'(PKT_LEN))); // R7

    AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !done) |=> (!irq && cnt_q == '0)); // R8

    AST_OVERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rdy_q && !rd_stat) |=> ovr_q); // R9

endmodule

// File: rtl/mouse_rx.sv
// Module: mouse_rx (top)
// Serial pointer receiver: tick prescaler, framing engine and buffer.
// Assumes: configuration inputs change only while the line is idle.
module mouse_rx #(
    parameter int DIV_W    = 16,
    parameter int OVS      = 16,
    parameter int DATA_MAX = 8,
    parameter int PKT_LEN  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rxd,
    input  logic [DIV_W-1:0]              cfg_div,
    input  logic                          cfg_len8,
    input  logic [1:0]                    cfg_par,
    input  logic                          cfg_stop2,
    input  logic                          cfg_pkt3,
    input  logic                          rd_en,
    input  logic [$clog2(PKT_LEN+1)-1:0]  rd_addr,
    output logic [DATA_MAX-1:0]           rd_data,
    output logic                          irq
);

    logic                tick;
    logic                done;
    logic [DATA_MAX-1:0] data;
    logic                perr;
    logic                ferr;

    mrx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_div (cfg_div),
        .tick    (tick)
    );

    mrx_frame #(.OVS(OVS), .DATA_MAX(DATA_MAX)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .tick      (tick),
        .cfg_len8  (cfg_len8),
        .cfg_par   (cfg_par),
        .cfg_stop2 (cfg_stop2),
        .done      (done),
        .data      (data),
        .perr      (perr),
        .ferr      (ferr)
    );

    mrx_buf #(.DATA_W(DATA_MAX), .PKT_LEN(PKT_LEN)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .din      (data),
        .din_perr (perr),
        .din_ferr (ferr),
        .cfg_pkt3 (cfg_pkt3),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq      (irq)
    );

endmodule

// File: tb/tb_mouse_rx.sv
module tb_mouse_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic [15:0] cfg_div = 16'd0;
    logic        cfg_len8 = 1'b1;
    logic [1:0]  cfg_par = 2'b00;
    logic        cfg_stop2 = 1'b0;
    logic        cfg_pkt3 = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [7:0]  rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mouse_rx dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_div(cfg_div),
        .cfg_len8(cfg_len8), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
        .cfg_pkt3(cfg_pkt3), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       l8;
        logic [1:0] par;
        logic       s2;
        logic       bp;
        logic       bs1;
        logic       bs2;
        logic [7:0] exp_stat;
        logic [7:0] exp_data;
    } vec_t;

    // status: bit0 ready, bit1 parity, bit2 framing, bit3 overrun, 5:4 count
    localparam vec_t VEC [8] = '{
        '{8'hA5, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'hA5},
        '{8'h53, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h53},
        '{8'h3C, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h3C},
        '{8'hC3, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h13, 8'hC3},
        '{8'h5A, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h15, 8'h5A},
        '{8'hFF, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h7F},
        '{8'h81, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 8'h15, 8'h81},
        '{8'h6E, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h13, 8'h6E}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic l8, input logic [1:0] par,
                              input logic s2, input logic bp, input logic bs1, input logic bs2);
        int   bt = 16 * (int'(cfg_div) + 1);
        int   nb = l8 ? 8 : 7;
        logic p  = 1'b0;
        cfg_len8 = l8; cfg_par = par; cfg_stop2 = s2;
        rxd = 1'b0; hold(bt);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i]; p = p ^ d[i]; hold(bt);
        end
        if (par == 2'b01 || par == 2'b10) begin
            rxd = ((par == 2'b10) ? ~p : p) ^ bp; hold(bt);
        end
        rxd = ~bs1; hold(bt);
        if (s2) begin
            rxd = ~bs2; hold(bt);
        end
        rxd = 1'b1; hold(2 * bt);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_en = 1'b0; rd_addr = a;
        @(negedge clk);
        v = rd_data;
        @(posedge clk); #1;
    endtask

    task automatic ack();
        rd_addr = 2'd0; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        hold(4);
        rst_n = 1'b1;
        hold(2);

        // R10: reset state
        rd(2'd0, v); check("R10 status after reset", v, 8'h00);
        check("R10 irq after reset", {7'd0, irq}, 8'h00);
        rd(2'd1, v); check("R10 entry1 after reset", v, 8'h00);
        rd(2'd3, v); check("R10 entry3 after reset", v, 8'h00);

        // Vector table in byte mode: R2 R3 R4 R6
        for (int k = 0; k < 8; k++) begin
            send_frame(VEC[k].d, VEC[k].l8, VEC[k].par, VEC[k].s2,
                       VEC[k].bp, VEC[k].bs1, VEC[k].bs2);
            check($sformatf("R6 irq vec %0d", k), {7'd0, irq}, 8'h01);
            rd(2'd1, v); check($sformatf("R2 R3 R4 R6 data vec %0d", k), v, VEC[k].exp_data);
            rd(2'd0, v); check($sformatf("R2 R3 R4 R6 status vec %0d", k), v, VEC[k].exp_stat);
            ack();
        end

        // R8: acknowledge clears everything
        send_frame(8'hC3, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0);
        ack();
        rd(2'd0, v); check("R8 status after ack", v, 8'h00);
        check("R8 irq after ack", {7'd0, irq}, 8'h00);

        // R5: short low glitch ignored
        rxd = 1'b0; hold(4); rxd = 1'b1; hold(400);
        rd(2'd0, v); check("R5 glitch status", v, 8'h00);
        rd(2'd1, v); check("R5 glitch entry unchanged", v, 8'hC3);

        // R7: packet mode
        cfg_pkt3 = 1'b1;
        send_frame(8'h11, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(8'h22, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R7 no irq after two", {7'd0, irq}, 8'h00);
        rd(2'd0, v); check("R7 status after two", v, 8'h20);
        send_frame(8'h33, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R7 irq after third", {7'd0, irq}, 8'h01);
        rd(2'd0, v); check("R7 status after third", v, 8'h31);
        rd(2'd1, v); check("R7 entry1", v, 8'h11);
        rd(2'd2, v); check("R7 entry2", v, 8'h22);
        rd(2'd3, v); check("R7 entry3", v, 8'h33);

        // R9: overrun in packet mode
        send_frame(8'h44, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(2'd0, v); check("R9 pkt overrun status", v, 8'h39);
        rd(2'd1, v); check("R9 pkt entry kept", v, 8'h11);
        ack();

        // R9: overrun in byte mode
        cfg_pkt3 = 1'b0;
        send_frame(8'h77, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(8'h88, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(2'd0, v); check("R9 byte overrun status", v, 8'h19);
        rd(2'd1, v); check("R9 byte entry kept", v, 8'h77);
        ack();

        // R1: slower bit rate
        cfg_div = 16'd2;
        hold(4);
        send_frame(8'h96, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(2'd0, v); check("R1 div2 status", v, 8'h11);
        rd(2'd1, v); check("R1 div2 data", v, 8'h96);
        ack();

        summary();
        $finish;
    end

endmodule